// File: doc/BRIEF.md
# Delayed ADC Trigger Compare Unit

This block makes two independent start pulses for an analog-to-digital converter, channel A and channel B. Both are taken from an up/down timer counter that lies outside the block. Each channel holds an active trigger position and compares the counter with it. When the two are equal, the channel emits a single-clock pulse. The pulse is only emitted if the channel is enabled for the current count direction and if the interrupt-skipping gate allows it.

Software writes a trigger position into a per-channel staging buffer. The block copies that buffer into the active position at the carrier crest, at the trough, at both, or never, as the transfer field selects. A small register write port loads the control word, the buffers and the active positions. The counter value, direction, crest and trough events, skip-permit flags and mode flags all come in as inputs.

Top module: `adc_trig_delay`

## Requirements
- R1: A channel's trigger output goes high for one clock, on the clock after a cycle in which the counter is running and the counter value equals that channel's active position, provided the channel is enabled for the direction and the gate is open. Channels A and B act independently.
- R2: The control field xfer, bits [1:0], selects when the buffer is copied to the active position: 00 never, 01 at crest, 10 at trough, 11 at both. In a clock where a copy and a match coincide, the compare uses the old position, and the new position applies from the next clock.
- R3: Control bits 2/3 are the up/down enables of A, and bits 4/5 are the up/down enables of B. A match is reported only when the enable for the direction (cnt_up=1 means up) is set.
- R4: Control bits 6/7 link A to crest/trough skipping, and bits 8/9 do the same for B. With one link set, the trigger is issued only while the matching permit input is high. With both links set, either permit suffices. With no link set, the gate is always open.
- R5: After reset, both triggers are low, the control word is zero, and the buffers and active positions are all-ones.
- R6: A control write (address 0) made while cnt_run is high is ignored.
- R7: When pwm_cmp is low, xfer bit 1, all four link bits and both down enables act as zero.
- R8: When skip_en is low, all link bits act as zero.
- R9: The write addresses are 0 control, 1 buffer A, 2 buffer B, 3 active A and 4 active B. The buffers and active positions can be written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_run | input | 1 | Counter running |
| cnt_val | input | W | Counter value |
| cnt_up | input | 1 | 1 = counting up |
| crest | input | 1 | Crest event pulse |
| trough | input | 1 | Trough event pulse |
| pwm_cmp | input | 1 | Complementary up/down mode |
| skip_en | input | 1 | Interrupt skipping enabled |
| crest_ok | input | 1 | Crest skip permit |
| trough_ok | input | 1 | Trough skip permit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| trig_a | output | 1 | Channel A start pulse |
| trig_b | output | 1 | Channel B start pulse |

## Verification
The hardest situation to reach is a buffer copy landing in the same clock as a match on the old position. The stimulus stages a new value in the buffer and then presents the old position together with the crest pulse, which shows whether the compare still used the old value. It then presents the new value on its own. The ignored control write needs a write issued while cnt_run is high, followed by a match that the previous control word still enables.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int unsigned CTRL_W = 10;
    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_BUF_A = 3'd1;
    localparam logic [2:0] ADDR_BUF_B = 3'd2;
    localparam logic [2:0] ADDR_ACT_A = 3'd3;
    localparam logic [2:0] ADDR_ACT_B = 3'd4;

    typedef struct packed {
        logic       lt_b;
        logic       lc_b;
        logic       lt_a;
        logic       lc_a;
        logic       dn_b;
        logic       up_b;
        logic       dn_a;
        logic       up_a;
        logic [1:0] xfer;
    } trig_ctrl_t;
endpackage

// File: rtl/adc_trig_chan.sv
module adc_trig_chan #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_buf,
    input  logic         wr_act,
    input  logic [W-1:0] wr_data,
    input  logic         xfer_now,
    input  logic         cnt_run,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_up,
    input  logic         up_en,
    input  logic         dn_en,
    input  logic         link_c,
    input  logic         link_t,
    input  logic         crest_ok,
    input  logic         trough_ok,
    output logic         trig
);
    typedef struct packed {
        logic [W-1:0] buf_v;
        logic [W-1:0] act;
        logic         trig;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic dir_ok, gate_ok;

    always_comb begin
        st_d    = st_q;
        dir_ok  = cnt_up ? up_en : dn_en;
        gate_ok = (!link_c && !link_t) || (link_c && crest_ok) || (link_t && trough_ok);
        st_d.trig = cnt_run && (cnt_val == st_q.act) && dir_ok && gate_ok;
        if (wr_buf) st_d.buf_v = wr_data;
        if (xfer_now) st_d.act = st_q.buf_v;
        if (wr_act) st_d.act = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.buf_v <= '1;
            st_q.act   <= '1;
            st_q.trig  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig = st_q.trig;

    a_r3_dir_enable: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(cnt_up ? up_en : dn_en));
    a_r4_skip_gate: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(!(link_c || link_t) || (link_c && crest_ok) || (link_t && trough_ok)));
    a_r1_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(cnt_run));
    a_r2_xfer_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_now && !wr_act) |=> (st_q.act == $past(st_q.buf_v)));
endmodule

// File: rtl/adc_trig_delay.sv
module adc_trig_delay #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_run,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_up,
    input  logic         crest,
    input  logic         trough,
    input  logic         pwm_cmp,
    input  logic         skip_en,
    input  logic         crest_ok,
    input  logic         trough_ok,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         trig_a,
    output logic         trig_b
);
    import adc_trig_pkg::*;
    localparam int unsigned NCH = 2;

    trig_ctrl_t ctrl_d, ctrl_q;
    logic [1:0] xfer_eff;
    logic       xfer_now;
    logic [NCH-1:0] up_v, dn_v, lc_v, lt_v, wbuf_v, wact_v, trig_v;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_addr == ADDR_CTRL && !cnt_run)
            ctrl_d = trig_ctrl_t'(wr_data[CTRL_W-1:0]);
        xfer_eff = {ctrl_q.xfer[1] & pwm_cmp, ctrl_q.xfer[0]};
        xfer_now = (crest && xfer_eff[0]) || (trough && xfer_eff[1]);
        up_v   = {ctrl_q.up_b, ctrl_q.up_a};
        dn_v   = {ctrl_q.dn_b, ctrl_q.dn_a} & {NCH{pwm_cmp}};
        lc_v   = {ctrl_q.lc_b, ctrl_q.lc_a} & {NCH{pwm_cmp & skip_en}};
        lt_v   = {ctrl_q.lt_b, ctrl_q.lt_a} & {NCH{pwm_cmp & skip_en}};
        wbuf_v = {wr_en && wr_addr == ADDR_BUF_B, wr_en && wr_addr == ADDR_BUF_A};
        wact_v = {wr_en && wr_addr == ADDR_ACT_B, wr_en && wr_addr == ADDR_ACT_A};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        adc_trig_chan #(.W(W)) i_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_buf(wbuf_v[i]), .wr_act(wact_v[i]), .wr_data(wr_data),
            .xfer_now(xfer_now), .cnt_run(cnt_run), .cnt_val(cnt_val),
            .cnt_up(cnt_up), .up_en(up_v[i]), .dn_en(dn_v[i]),
            .link_c(lc_v[i]), .link_t(lt_v[i]),
            .crest_ok(crest_ok), .trough_ok(trough_ok),
            .trig(trig_v[i])
        );
    end

    assign trig_a = trig_v[0];
    assign trig_b = trig_v[1];

    a_r6_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_run |=> $stable(ctrl_q));
    a_r7_down_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_cmp && !cnt_up) |=> !(trig_a || trig_b));
endmodule

// File: tb/test_adc_trig_delay.sv
module test_adc_trig_delay;
    localparam int W = 16;
    logic clk = 0, rst_n = 0;
    logic cnt_run = 0, cnt_up = 1, crest = 0, trough = 0;
    logic pwm_cmp = 0, skip_en = 0, crest_ok = 0, trough_ok = 0;
    logic wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [W-1:0] wr_data = 0, cnt_val = 0;
    logic trig_a, trig_b;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    adc_trig_delay #(.W(W)) i_adc_trig_delay (
        .clk(clk), .rst_n(rst_n), .cnt_run(cnt_run), .cnt_val(cnt_val),
        .cnt_up(cnt_up), .crest(crest), .trough(trough), .pwm_cmp(pwm_cmp),
        .skip_en(skip_en), .crest_ok(crest_ok), .trough_ok(trough_ok),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_a(trig_a), .trig_b(trig_b));

    task automatic chk(input string req, input logic ea, input logic eb);
        n_chk++;
        if (trig_a !== ea || trig_b !== eb) begin
            n_fail++;
            $display("FAIL %s: trig_a/b=%b%b expected %b%b at %0t", req, trig_a, trig_b, ea, eb, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic run = 0);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; cnt_run = run; cnt_val = 0; crest = 0; trough = 0;
        @(negedge clk);
        wr_en = 0; cnt_run = 0;
    endtask

    task automatic cyc(input logic [W-1:0] v, input logic up, input logic c = 0, input logic t = 0);
        @(negedge clk);
        cnt_run = 1; cnt_val = v; cnt_up = up; crest = c; trough = t;
        @(posedge clk); #1;
        cnt_run = 0; crest = 0; trough = 0;
    endtask

    task automatic t_reset_vals;
        chk("R5 reset", 0, 0);
        wr(3'd0, 16'h0014);            // up_a, up_b
        cyc(16'hFFFF, 1); chk("R5 all-ones position", 1, 1);
        cyc(16'h0000, 1); chk("R5 no match at zero", 0, 0);
    endtask

    task automatic t_basic;
        wr(3'd3, 16'd5); wr(3'd4, 16'd7); wr(3'd0, 16'h0004);
        cyc(5, 1); chk("R1 A match", 1, 0);
        cyc(6, 1); chk("R1 no match", 0, 0);
        wr(3'd0, 16'h0010);
        cyc(7, 1); chk("R1 B match", 0, 1);
        cyc(7, 0); chk("R3 B down disabled", 0, 0);
        cyc(5, 1); chk("R9 A independent", 0, 0);
    endtask

    task automatic t_direction;
        wr(3'd0, 16'h000C);
        pwm_cmp = 0;
        cyc(5, 0); chk("R7 down enable masked", 0, 0);
        pwm_cmp = 1;
        cyc(5, 0); chk("R3 down match", 1, 0);
        pwm_cmp = 0;
    endtask

    task automatic t_transfer;
        wr(3'd0, 16'h0005); wr(3'd1, 16'd9);
        cyc(9, 1); chk("R2 buffer not yet active", 0, 0);
        cyc(5, 1, 1, 0); chk("R2 old value on copy clock", 1, 0);
        cyc(9, 1); chk("R2 new value applies", 1, 0);
        wr(3'd0, 16'h0006); wr(3'd1, 16'd3);
        cyc(9, 1, 0, 1); chk("R7 trough copy masked", 1, 0);
        cyc(3, 1); chk("R7 no trough copy", 0, 0);
        cyc(9, 1); chk("R7 old position kept", 1, 0);
    endtask

    task automatic t_lock;
        wr(3'd0, 16'h0004);
        wr(3'd0, 16'h0000, 1);
        cyc(9, 1); chk("R6 running write ignored", 1, 0);
    endtask

    task automatic t_skip;
        pwm_cmp = 1; skip_en = 1;
        wr(3'd0, 16'h0044);
        crest_ok = 0; cyc(9, 1); chk("R4 crest skipped", 0, 0);
        crest_ok = 1; cyc(9, 1); chk("R4 crest permitted", 1, 0);
        wr(3'd0, 16'h00C4);
        crest_ok = 0; trough_ok = 1; cyc(9, 1); chk("R4 either permit", 1, 0);
        trough_ok = 0; cyc(9, 1); chk("R4 neither permit", 0, 0);
        skip_en = 0; cyc(9, 1); chk("R8 links ignored", 1, 0);
        skip_en = 1; pwm_cmp = 0; cyc(9, 1); chk("R7 links masked", 1, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                #1;
                t_reset_vals();
                t_basic();
                t_direction();
                t_transfer();
                t_lock();
                t_skip();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule